// File: doc/BRIEF.md
# Triggered Burst Frame Capture

This block sits between a free-running complex sample stream and the write channel of a DMA engine. The stream delivers four complex samples per clock, each a 16-bit real and a 16-bit imaginary part, packed into a 128-bit word. A single trigger pulse opens one capture window. The window holds a configured number of frames, each of 512 samples (128 beats). The block sends these beats out as an AXI4-Stream master and marks the last beat of every frame with TLAST.

The window is not aligned to any frame structure in the incoming stream. Framing is counted from the first beat captured after the trigger, so the first output frame can start anywhere in a source frame. Once the last beat of the window has been handed over, the block drops its busy flag and waits for the next trigger. A sticky overflow flag records any input beat that had to be dropped because the output was stalled.

Top module: `burst_capture_top`

## Requirements
- R1: After reset, busy, TVALID and overflow are low. A trigger pulse seen while busy is low makes busy high from the next clock. Busy stays high until the clock edge at which the final beat of the window is transferred (TVALID and TREADY both high).
- R2: One window carries exactly nFrames × 128 output beats. The frame count is sampled on the trigger cycle.
- R3: A frame count of 0 is treated as 1, giving a window of 128 beats.
- R4: TLAST is high on every 128th transferred beat of a window, counted from the first, and is low on every other transferred beat.
- R5: The first beat of the window is the first valid input beat accepted after the trigger cycle, at whatever position it holds in the source stream.
- R6: A trigger pulse that arrives while busy is high has no effect on the window length or on the data.
- R7: During a capture, an input beat is accepted when input valid is high and the output register is free (TVALID low or TREADY high). Accepted beats appear on TDATA unchanged (lane 0 in bits 31:0, real part in the low 16 bits), in order, each exactly once. No beat is accepted outside a capture.
- R8: Overflow is set when a valid input beat arrives during a capture while TVALID is high and TREADY is low. It stays set until the next trigger that starts a window.
- R9: While TVALID is high and TREADY is low, TVALID, TDATA and TLAST keep their values on the next clock.
- R10: Any frame count from 1 to 1024 gives a complete window of that many frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigPulse | input | 1 | One-cycle request to start a window |
| frameCfg | input | 11 | Number of frames per window (0 means 1) |
| inData | input | 128 | Four packed complex input samples |
| inValid | input | 1 | Input beat present |
| mTvalid | output | 1 | AXI4-Stream TVALID |
| mTready | input | 1 | AXI4-Stream TREADY |
| mTdata | output | 128 | AXI4-Stream TDATA |
| mTlast | output | 1 | AXI4-Stream TLAST, last beat of each frame |
| busy | output | 1 | Window in progress or final beat still pending |
| overflow | output | 1 | Sticky dropped-beat flag |

## Verification
The frame-spacing assertion counts transferred beats from reset modulo 128. It therefore relies on every window being made of whole frames and on no beat reaching the output outside a window. The stimulus never violates this, because it drives input beats at any time, including while idle, and the design drops those idle beats. The assertions also assume that the trigger and TREADY are synchronous and change only away from the clock edge. The bench meets this by driving every input on the falling edge, with random valid and ready rates and with triggers issued in the middle of a capture.

// File: rtl/capture_pkg.sv
package capture_pkg;
  typedef struct packed {
    logic take;       // load the output register with the current input beat
    logic markLast;   // the beat being loaded closes a frame
    logic dropBeat;   // a valid beat arrived while the output was stalled
    logic clearFlag;  // a new window starts
  } capStrobe_t;
endpackage

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import capture_pkg::*;
#(
  parameter int BEATS_PER_FRAME = 128,
  parameter int FRAME_CNT_W     = 11
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   trigPulse,
  input  logic [FRAME_CNT_W-1:0] frameCfg,
  input  logic                   inValid,
  input  logic                   slotFree,
  input  logic                   outPending,
  output logic                   capturing,
  output capStrobe_t             strobe
);
  localparam int BEAT_W = $clog2(BEATS_PER_FRAME);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS_PER_FRAME - 1);

  logic [BEAT_W-1:0]      beatIdx;
  logic [FRAME_CNT_W-1:0] frameIdx;
  logic [FRAME_CNT_W-1:0] frameTarget;
  logic startGo, frameEnd, windowEnd;

  assign startGo   = trigPulse && !capturing && !outPending;
  assign frameEnd  = (beatIdx == LAST_BEAT);
  assign windowEnd = frameEnd && (frameIdx == frameTarget - 1'b1);

  always_comb begin
    strobe.take      = capturing && inValid && slotFree;
    strobe.markLast  = frameEnd;
    strobe.dropBeat  = capturing && inValid && !slotFree;
    strobe.clearFlag = startGo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capturing   <= 1'b0;
      beatIdx     <= '0;
      frameIdx    <= '0;
      frameTarget <= FRAME_CNT_W'(1);
    end else if (startGo) begin
      capturing   <= 1'b1;
      beatIdx     <= '0;
      frameIdx    <= '0;
      frameTarget <= (frameCfg == '0) ? FRAME_CNT_W'(1) : frameCfg;
    end else if (strobe.take) begin
      beatIdx <= frameEnd ? '0 : beatIdx + 1'b1;
      if (frameEnd) frameIdx <= frameIdx + 1'b1;
      if (windowEnd) capturing <= 1'b0;
    end
  end
endmodule

// File: rtl/capture_dp.sv
module capture_dp
  import capture_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic              mTready,
  output logic              slotFree,
  output logic              mTvalid,
  output logic [DATA_W-1:0] mTdata,
  output logic              mTlast,
  output logic              overflow
);
  assign slotFree = !mTvalid || mTready;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mTvalid <= 1'b0;
      mTdata  <= '0;
      mTlast  <= 1'b0;
    end else if (strobe.take) begin
      mTvalid <= 1'b1;
      mTdata  <= inData;
      mTlast  <= strobe.markLast;
    end else if (mTready) begin
      mTvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 overflow <= 1'b0;
    else if (strobe.clearFlag) overflow <= 1'b0;
    else if (strobe.dropBeat)  overflow <= 1'b1;
  end
endmodule

// File: rtl/burst_capture_top.sv
module burst_capture_top
  import capture_pkg::*;
#(
  parameter int SAMPLE_W      = 32,
  parameter int LANES         = 4,
  parameter int FRAME_SAMPLES = 512,
  parameter int MAX_FRAMES    = 1024,
  localparam int DATA_W       = SAMPLE_W * LANES,
  localparam int BEATS_PER_FRAME = FRAME_SAMPLES / LANES,
  localparam int FRAME_CNT_W  = $clog2(MAX_FRAMES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   trigPulse,
  input  logic [FRAME_CNT_W-1:0] frameCfg,
  input  logic [DATA_W-1:0]      inData,
  input  logic                   inValid,
  output logic                   mTvalid,
  input  logic                   mTready,
  output logic [DATA_W-1:0]      mTdata,
  output logic                   mTlast,
  output logic                   busy,
  output logic                   overflow
);
  capStrobe_t strobe;
  logic capturing, slotFree;

  capture_ctrl #(
    .BEATS_PER_FRAME(BEATS_PER_FRAME),
    .FRAME_CNT_W(FRAME_CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .trigPulse(trigPulse), .frameCfg(frameCfg),
    .inValid(inValid), .slotFree(slotFree), .outPending(mTvalid),
    .capturing(capturing), .strobe(strobe)
  );

  capture_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .mTready(mTready), .slotFree(slotFree), .mTvalid(mTvalid),
    .mTdata(mTdata), .mTlast(mTlast), .overflow(overflow)
  );

  assign busy = capturing || mTvalid;
endmodule

// File: rtl/capture_checker.sv
module capture_checker #(
  parameter int DATA_W = 128,
  parameter int BEATS_PER_FRAME = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              mTvalid,
  input logic              mTready,
  input logic [DATA_W-1:0] mTdata,
  input logic              mTlast,
  input logic              overflow
);
  localparam int CW = $clog2(BEATS_PER_FRAME);
  logic [CW-1:0] hsCnt;
  logic hs;
  assign hs = mTvalid && mTready;

  always_ff @(posedge clk) begin
    if (!rstN)   hsCnt <= '0;
    else if (hs) hsCnt <= hsCnt + 1'b1;
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mTvalid && !mTready) |=> (mTvalid && $stable(mTdata) && $stable(mTlast)));

  assert_last_spacing_R4: assert property (@(posedge clk) disable iff (!rstN)
    hs |-> (mTlast == (hsCnt == CW'(BEATS_PER_FRAME - 1))));

  assert_busy_end_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(hs && mTlast));

  assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(busy));

  assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overflow) |-> $rose(busy));
endmodule

bind burst_capture_top capture_checker #(
  .DATA_W(DATA_W), .BEATS_PER_FRAME(BEATS_PER_FRAME)
) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .mTvalid(mTvalid), .mTready(mTready),
  .mTdata(mTdata), .mTlast(mTlast), .overflow(overflow)
);

// File: tb/burst_capture_top_tb_top.sv
module burst_capture_top_tb_top;
  localparam int BPF = 128;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigPulse = 1'b0;
  logic [10:0] frameCfg = '0;
  logic [127:0] inData = '0;
  logic inValid = 1'b0;
  logic mTready = 1'b0;
  logic mTvalid, mTlast, busy, overflow;
  logic [127:0] mTdata;

  always #4 clk = ~clk;

  burst_capture_top dut_i (
    .clk(clk), .rstN(rstN), .trigPulse(trigPulse), .frameCfg(frameCfg),
    .inData(inData), .inValid(inValid), .mTvalid(mTvalid), .mTready(mTready),
    .mTdata(mTdata), .mTlast(mTlast), .busy(busy), .overflow(overflow)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model of the requirements
  bit mCap = 0, mOvf = 0, winOpen = 0;
  int mBeat = 0, mFrame = 0, mTarget = 1, hsWin = 0;
  logic [127:0] expQ[$];
  logic [127:0] heldData;
  logic heldLast;
  bit wasStalled = 0;

  function automatic int effFrames(input logic [10:0] c);
    return (c == 0) ? 1 : int'(c);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cycle(input bit trig, input bit v, input bit rdy, input logic [10:0] cfg);
    bit preBusy, hs, acc;
    trigPulse = trig; inValid = v; mTready = rdy; frameCfg = cfg;
    inData = {$urandom, $urandom, $urandom, $urandom};
    #1;
    preBusy = mCap || (expQ.size() > 0);
    chk(busy == preBusy, "R1", "busy", 128'(busy), 128'(preBusy));
    chk(overflow == mOvf, "R8", "overflow", 128'(overflow), 128'(mOvf));
    chk(mTvalid == (expQ.size() > 0), "R7", "tvalid", 128'(mTvalid), 128'(expQ.size() > 0));
    if (wasStalled)
      chk(mTdata == heldData && mTlast == heldLast, "R9", "stall hold", mTdata, heldData);
    hs = mTvalid && mTready;
    if (hs && expQ.size() > 0) begin
      chk(mTdata == expQ[0], (hsWin == 0) ? "R5" : "R7", "tdata", mTdata, expQ[0]);
      chk(mTlast == ((hsWin % BPF) == BPF - 1), "R4", "tlast", 128'(mTlast),
          128'((hsWin % BPF) == BPF - 1));
      void'(expQ.pop_front());
      hsWin++;
    end
    wasStalled = mTvalid && !mTready;
    heldData = mTdata; heldLast = mTlast;
    acc = mCap && v && (!mTvalid || rdy);
    if (mCap && v && !acc) mOvf = 1;
    if (acc) begin
      expQ.push_back(inData);
      mBeat++;
      if (mBeat == BPF) begin mBeat = 0; mFrame++; end
      if (mFrame == mTarget) mCap = 0;
    end
    if (trig && !preBusy) begin
      mCap = 1; mBeat = 0; mFrame = 0; mTarget = effFrames(cfg);
      mOvf = 0; hsWin = 0; winOpen = 1;
    end
    if (winOpen && !mCap && expQ.size() == 0) begin
      chk(hsWin == mTarget * BPF, "R2 R6", "window beats", 128'(hsWin), 128'(mTarget * BPF));
      winOpen = 0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runWindow(input logic [10:0] cfg, input int pv, input int pr, input bit midTrig);
    int lead = $urandom_range(0, 5);
    for (int i = 0; i < lead; i++) cycle(0, 1, 1, cfg);
    cycle(1, $urandom_range(0, 99) < pv, 1, cfg);
    while (mCap || expQ.size() > 0)
      cycle(midTrig && ($urandom_range(0, 49) == 0),
            $urandom_range(0, 99) < pv, $urandom_range(0, 99) < pr,
            11'($urandom_range(0, 7)));
    cycle(0, 0, 1, cfg);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected under 190000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state, idle beats ignored (R7)
    for (int i = 0; i < 4; i++) cycle(0, 1, 1, 11'd2);
    // R2 single frame, full rate
    runWindow(11'd1, 100, 100, 0);
    // R3 zero means one frame, with stalls
    runWindow(11'd0, 70, 60, 0);
    // R4 R5 R6 R7 random rates, triggers while busy
    for (int k = 0; k < 6; k++) runWindow(11'($urandom_range(1, 3)), 30 + 10 * k, 40 + 10 * k, 1);
    // R8 directed overflow: valid with output stalled
    cycle(1, 0, 0, 11'd1);
    cycle(0, 1, 0, 11'd1);
    cycle(0, 1, 0, 11'd1);
    chk(overflow == 1'b1, "R8", "overflow set", 128'(overflow), 128'(1));
    while (mCap || expQ.size() > 0) cycle(0, 1, 1, 11'd1);
    chk(overflow == 1'b1, "R8", "overflow sticky", 128'(overflow), 128'(1));
    cycle(1, 0, 1, 11'd1);
    chk(overflow == 1'b0, "R8", "overflow cleared", 128'(overflow), 128'(0));
    while (mCap || expQ.size() > 0) cycle(0, 1, 1, 11'd1);
    cycle(0, 0, 1, 11'd1);
    // R10 largest frame count at full rate
    runWindow(11'd1024, 100, 100, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule